// File: doc/BRIEF.md
# Triplet-Grouped Reorder Buffer

This block keeps track of in-flight micro-operations that a decoder delivers three at a time. Each accepted triplet takes one group entry in a circular queue and receives a group tag. The execution lanes finish operations independently and in any order. Each lane reports a finished operation on its own completion port as a (group tag, slot index) pair.

A group can leave the buffer only when all three of its slots are finished. Groups leave strictly in the order in which they were allocated, and at most one group leaves per clock. When the allocator marks a slot as unused, that slot counts as finished at once. A global flush empties the buffer in one cycle, and allocation then restarts at tag 0.

Top module: `trob_triplet`

## Requirements
- R1: After reset, `alloc_ready` is 1, `retire_valid` is 0, and `alloc_tag` is 0.
- R2: Each accepted allocation (`alloc_valid` and `alloc_ready` both high at a clock edge) takes the group tag shown on `alloc_tag`. The tag then advances by one, and after DEPTH-1 it wraps to 0.
- R3: When DEPTH groups are held, `alloc_ready` is 0. An `alloc_valid` request in that state is ignored and `alloc_tag` does not change.
- R4: `retire_valid` rises only when the oldest group has all three slots finished. `retire_tag` then shows the tag of that group.
- R5: Completion port p sets the finished bit of slot `cmp_slot[2p+1:2p]` (0, 1 or 2) in group `cmp_tag[5p+4:5p]`. Any port may report any slot, in any order, and several ports may report in the same cycle.
- R6: Groups retire in allocation order. A younger group whose slots are all finished waits until every older group has retired.
- R7: Bit s of `alloc_used` set to 0 marks slot s of the new triplet as empty, and an empty slot counts as already finished. A triplet with `alloc_used` = 000 can retire in the cycle after it is allocated.
- R8: At most one group retires per clock. Groups that are ready back to back retire on consecutive cycles, with `retire_tag` advancing by one each cycle.
- R9: A flush drops every held group and all finished bits, and it blocks allocation and retirement in its own cycle. In the next cycle `alloc_ready` is 1, `retire_valid` is 0, and `alloc_tag` and `retire_tag` are both 0.
- R10: An allocation and a retirement in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties the buffer |
| alloc_valid | input | 1 | A triplet is offered |
| alloc_used | input | 3 | Per-slot occupancy of the offered triplet (0 = empty slot) |
| alloc_ready | output | 1 | Space is free; the offered triplet is taken at this edge |
| alloc_tag | output | 5 | Tag that the offered triplet receives |
| cmp_valid | input | 3 | One completion strobe per lane |
| cmp_tag | input | 15 | Group tag per lane, 5 bits each, lane 0 in the low bits |
| cmp_slot | input | 6 | Slot index per lane, 2 bits each, lane 0 in the low bits |
| retire_valid | output | 1 | The oldest group leaves at this edge |
| retire_tag | output | 5 | Tag of the oldest group |

## Verification
The bench targets four failure modes:
- **Order of retirement.** A younger group finishes before an older one. A design that retired out of order, or scanned for any finished group, would pulse `retire_valid` too early or with the wrong tag.
- **Full condition and tag wrap.** The bench fills all 24 entries and offers one triplet too many. A design with an off-by-one count would accept the extra triplet and overwrite the oldest group, or would stall one entry early.
- **Empty slots and same-cycle allocate/retire.** A design that ignored `alloc_used` would hold those groups forever. A design that let the two events conflict would lose either the new group or the retirement.
- **Flush.** Groups that were partly finished must never surface afterwards, and numbering must restart at tag 0.

// File: rtl/trob_pkg.sv
`timescale 1ns/1ps
package trob_pkg;

   // Number of micro-operations carried by one group.
   localparam int TRIP = 3;

   // Width of the slot index carried by each completion port.
   localparam int SLOT_W = $clog2(TRIP);

   typedef logic [TRIP-1:0] trip_mask_t;

   typedef logic [SLOT_W-1:0] slot_idx_t;

endpackage

// File: rtl/trob_ptr_ctrl.sv
`timescale 1ns/1ps
module trob_ptr_ctrl #(
   parameter int DEPTH = 24,
   parameter int TW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic          pop,
   output logic [TW-1:0] head,
   output logic [TW-1:0] tail,
   output logic          full,
   output logic          empty
);

   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [TW-1:0] LAST  = TW'(DEPTH - 1);
   localparam logic [CW-1:0] CFULL = CW'(DEPTH);

   logic [CW-1:0] count;

   // Advance a pointer, wrapping at the last entry.
   function automatic logic [TW-1:0] step(input logic [TW-1:0] p);
      return (p == LAST) ? '0 : p + TW'(1);
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         head  <= '0;
         tail  <= '0;
         count <= '0;
      end else begin
         if (push) begin
            tail <= step(tail);
         end
         if (pop) begin
            head <= step(head);
         end
         case ({push, pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   assign full  = (count == CFULL);
   assign empty = (count == '0);

endmodule

// File: rtl/trob_done_array.sv
`timescale 1ns/1ps
module trob_done_array
   import trob_pkg::*;
#(
   parameter int DEPTH = 24,
   parameter int TW    = $clog2(DEPTH),
   parameter int NCMP  = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 flush,
   input  logic                 wr_en,
   input  logic [TW-1:0]        wr_idx,
   input  trip_mask_t           wr_used,
   input  logic                 clr_en,
   input  logic [TW-1:0]        clr_idx,
   input  logic [NCMP-1:0]      cmp_valid,
   input  logic [NCMP*TW-1:0]   cmp_tag,
   input  logic [NCMP*SLOT_W-1:0] cmp_slot,
   output logic [DEPTH-1:0]     occ,
   output trip_mask_t           done [DEPTH]
);

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      localparam logic [TW-1:0] MY_TAG = TW'(e);

      trip_mask_t hit;

      // Collect the slots that any lane reports as finished for this entry.
      always_comb begin
         hit = '0;
         for (int p = 0; p < NCMP; p++) begin
            for (int s = 0; s < TRIP; s++) begin
               if (cmp_valid[p] &&
                   cmp_tag[p*TW +: TW] == MY_TAG &&
                   cmp_slot[p*SLOT_W +: SLOT_W] == SLOT_W'(s)) begin
                  hit[s] = 1'b1;
               end
            end
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n || flush) begin
            occ[e]  <= 1'b0;
            done[e] <= '0;
         end else if (wr_en && wr_idx == MY_TAG) begin
            occ[e]  <= 1'b1;
            done[e] <= ~wr_used;
         end else if (clr_en && clr_idx == MY_TAG) begin
            occ[e]  <= 1'b0;
            done[e] <= '0;
         end else if (occ[e]) begin
            done[e] <= done[e] | hit;
         end
      end
   end

endmodule

// File: rtl/trob_retire_sel.sv
`timescale 1ns/1ps
module trob_retire_sel
   import trob_pkg::*;
#(
   parameter int DEPTH = 24,
   parameter int TW    = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0] occ,
   input  trip_mask_t       done [DEPTH],
   input  logic [TW-1:0]    head,
   output logic             head_ready
);

   logic       head_occ;
   trip_mask_t head_done;

   // Select the oldest entry with a one-hot AND-OR mux, avoiding an
   // out-of-range index when DEPTH is not a power of two.
   always_comb begin
      head_occ  = 1'b0;
      head_done = '0;
      for (int e = 0; e < DEPTH; e++) begin
         if (head == TW'(e)) begin
            head_occ  = occ[e];
            head_done = done[e];
         end
      end
   end

   assign head_ready = head_occ && (&head_done);

endmodule

// File: rtl/trob_triplet.sv
`timescale 1ns/1ps
module trob_triplet
   import trob_pkg::*;
#(
   parameter int DEPTH = 24,
   parameter int NCMP  = 3,
   parameter int TW    = $clog2(DEPTH)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   flush,
   input  logic                   alloc_valid,
   input  logic [TRIP-1:0]        alloc_used,
   output logic                   alloc_ready,
   output logic [TW-1:0]          alloc_tag,
   input  logic [NCMP-1:0]        cmp_valid,
   input  logic [NCMP*TW-1:0]     cmp_tag,
   input  logic [NCMP*SLOT_W-1:0] cmp_slot,
   output logic                   retire_valid,
   output logic [TW-1:0]          retire_tag
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("trob_triplet: DEPTH must be at least 2");
   end
   if (NCMP < 1) begin : g_bad_ncmp
      $error("trob_triplet: NCMP must be at least 1");
   end
   if (TW < $clog2(DEPTH)) begin : g_bad_tw
      $error("trob_triplet: TW too narrow for DEPTH");
   end

   logic [TW-1:0]    head, tail;
   logic             full, empty;
   logic             push, pop, head_ready;
   logic [DEPTH-1:0] occ;
   trip_mask_t       done [DEPTH];

   assign alloc_ready  = !full && !flush;
   assign push         = alloc_valid && alloc_ready;
   assign retire_valid = head_ready && !flush;
   assign pop          = retire_valid;
   assign alloc_tag    = tail;
   assign retire_tag   = head;

   trob_ptr_ctrl #(
      .DEPTH (DEPTH),
      .TW    (TW)
   ) i_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .push  (push),
      .pop   (pop),
      .head  (head),
      .tail  (tail),
      .full  (full),
      .empty (empty)
   );

   trob_done_array #(
      .DEPTH (DEPTH),
      .TW    (TW),
      .NCMP  (NCMP)
   ) i_done (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .wr_en     (push),
      .wr_idx    (tail),
      .wr_used   (alloc_used),
      .clr_en    (pop),
      .clr_idx   (head),
      .cmp_valid (cmp_valid),
      .cmp_tag   (cmp_tag),
      .cmp_slot  (cmp_slot),
      .occ       (occ),
      .done      (done)
   );

   trob_retire_sel #(
      .DEPTH (DEPTH),
      .TW    (TW)
   ) i_sel (
      .occ        (occ),
      .done       (done),
      .head       (head),
      .head_ready (head_ready)
   );

endmodule

// File: rtl/trob_triplet_chk.sv
`timescale 1ns/1ps
module trob_triplet_chk #(
   parameter int DEPTH = 24,
   parameter int TW    = $clog2(DEPTH)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          flush,
   input logic          alloc_valid,
   input logic          alloc_ready,
   input logic [TW-1:0] alloc_tag,
   input logic          retire_valid,
   input logic [TW-1:0] retire_tag
);

   localparam int CW = $clog2(DEPTH + 1);

   // Occupancy rebuilt only from the handshakes seen at the ports.
   logic [CW-1:0] shadow;

   function automatic logic [TW-1:0] nxt(input logic [TW-1:0] t);
      return (t == TW'(DEPTH - 1)) ? '0 : t + TW'(1);
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         shadow <= '0;
      end else begin
         shadow <= shadow + CW'(alloc_valid && alloc_ready) - CW'(retire_valid);
      end
   end

   AST_TAG_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_valid && alloc_ready && !flush) |=> alloc_tag == nxt($past(alloc_tag))); // R2

   AST_TAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!(alloc_valid && alloc_ready) && !flush) |=> $stable(alloc_tag)); // R3

   AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (shadow == CW'(DEPTH)) |-> !alloc_ready); // R3

   AST_NO_RETIRE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (shadow == '0) |-> !retire_valid); // R4

   AST_RETIRE_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (retire_valid && !flush) |=> retire_tag == nxt($past(retire_tag))); // R6

   AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!retire_valid && !flush) |=> $stable(retire_tag)); // R8

   AST_FLUSH_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (alloc_ready && !retire_valid && alloc_tag == '0 && retire_tag == '0)); // R9

endmodule

bind trob_triplet trob_triplet_chk #(
   .DEPTH (DEPTH),
   .TW    (TW)
) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .flush        (flush),
   .alloc_valid  (alloc_valid),
   .alloc_ready  (alloc_ready),
   .alloc_tag    (alloc_tag),
   .retire_valid (retire_valid),
   .retire_tag   (retire_tag)
);

// File: tb/test_trob_triplet.sv
`timescale 1ns/1ps
module test_trob_triplet;

   localparam int DEPTH = 24;
   localparam int NCMP  = 3;
   localparam int TW    = 5;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           flush;
   logic           alloc_valid;
   logic [2:0]     alloc_used;
   logic           alloc_ready;
   logic [TW-1:0]  alloc_tag;
   logic [2:0]     cmp_valid;
   logic [14:0]    cmp_tag;
   logic [5:0]     cmp_slot;
   logic           retire_valid;
   logic [TW-1:0]  retire_tag;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   trob_triplet #(
      .DEPTH (DEPTH),
      .NCMP  (NCMP)
   ) i_trob_triplet (
      .clk          (clk),
      .rst_n        (rst_n),
      .flush        (flush),
      .alloc_valid  (alloc_valid),
      .alloc_used   (alloc_used),
      .alloc_ready  (alloc_ready),
      .alloc_tag    (alloc_tag),
      .cmp_valid    (cmp_valid),
      .cmp_tag      (cmp_tag),
      .cmp_slot     (cmp_slot),
      .retire_valid (retire_valid),
      .retire_tag   (retire_tag)
   );

   typedef struct packed {
      logic       av;
      logic [2:0] used;
      logic [2:0] cv;
      logic [14:0] ct;
      logic [5:0] cs;
      logic       fl;
      logic       erv;
      logic [4:0] ert;
      logic       ear;
      logic [4:0] eat;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 12;
   // Outputs are checked in the same cycle the inputs are applied.
   localparam vec_t VECS [NV] = '{
      '{1'b1, 3'b111, 3'b000, 15'd0, 6'd0, 1'b0, 1'b0, 5'd0, 1'b1, 5'd0, 4'd2},        // R2 group 0
      '{1'b1, 3'b111, 3'b001, {5'd0,5'd0,5'd0}, {2'd0,2'd0,2'd2}, 1'b0, 1'b0, 5'd0, 1'b1, 5'd1, 4'd5}, // R5
      '{1'b0, 3'b000, 3'b111, {5'd1,5'd1,5'd1}, {2'd1,2'd0,2'd2}, 1'b0, 1'b0, 5'd0, 1'b1, 5'd2, 4'd5}, // R5
      '{1'b0, 3'b000, 3'b100, {5'd0,5'd0,5'd0}, {2'd0,2'd0,2'd0}, 1'b0, 1'b0, 5'd0, 1'b1, 5'd2, 4'd6}, // R6
      '{1'b0, 3'b000, 3'b010, {5'd0,5'd0,5'd0}, {2'd0,2'd1,2'd0}, 1'b0, 1'b0, 5'd0, 1'b1, 5'd2, 4'd6}, // R6
      '{1'b0, 3'b000, 3'b000, 15'd0, 6'd0, 1'b0, 1'b1, 5'd0, 1'b1, 5'd2, 4'd4},        // R4
      '{1'b0, 3'b000, 3'b000, 15'd0, 6'd0, 1'b0, 1'b1, 5'd1, 1'b1, 5'd2, 4'd8},        // R8
      '{1'b1, 3'b000, 3'b000, 15'd0, 6'd0, 1'b0, 1'b0, 5'd2, 1'b1, 5'd2, 4'd7},        // R7
      '{1'b1, 3'b010, 3'b000, 15'd0, 6'd0, 1'b0, 1'b1, 5'd2, 1'b1, 5'd3, 4'd10},       // R10
      '{1'b0, 3'b000, 3'b001, {5'd0,5'd0,5'd3}, {2'd0,2'd0,2'd1}, 1'b0, 1'b0, 5'd3, 1'b1, 5'd4, 4'd7}, // R7
      '{1'b0, 3'b000, 3'b000, 15'd0, 6'd0, 1'b0, 1'b1, 5'd3, 1'b1, 5'd4, 4'd7},        // R7
      '{1'b0, 3'b000, 3'b000, 15'd0, 6'd0, 1'b0, 1'b0, 5'd4, 1'b1, 5'd4, 4'd4}         // R4
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle_inputs();
      flush       = 1'b0;
      alloc_valid = 1'b0;
      alloc_used  = 3'b111;
      cmp_valid   = '0;
      cmp_tag     = '0;
      cmp_slot    = '0;
   endtask

   task automatic do_reset();
      idle_inputs();
      rst_n = 1'b0;
      repeat (3) tick();
      rst_n = 1'b1;
      #1;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(20 * 100000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0 (run did not complete)");
      finish_run();
   end

   initial begin
      do_reset();
      // R1 reset state
      check(alloc_ready == 1'b1, "R1 alloc_ready", alloc_ready, 1);
      check(retire_valid == 1'b0, "R1 retire_valid", retire_valid, 0);
      check(alloc_tag == 5'd0, "R1 alloc_tag", alloc_tag, 0);

      // Vector table
      for (int i = 0; i < NV; i++) begin
         alloc_valid = VECS[i].av;
         alloc_used  = VECS[i].used;
         cmp_valid   = VECS[i].cv;
         cmp_tag     = VECS[i].ct;
         cmp_slot    = VECS[i].cs;
         flush       = VECS[i].fl;
         #1;
         check(retire_valid == VECS[i].erv, $sformatf("R%0d vec%0d retire_valid", VECS[i].req, i),
               retire_valid, VECS[i].erv);
         check(retire_tag == VECS[i].ert, $sformatf("R%0d vec%0d retire_tag", VECS[i].req, i),
               retire_tag, VECS[i].ert);
         check(alloc_ready == VECS[i].ear, $sformatf("R%0d vec%0d alloc_ready", VECS[i].req, i),
               alloc_ready, VECS[i].ear);
         check(alloc_tag == VECS[i].eat, $sformatf("R%0d vec%0d alloc_tag", VECS[i].req, i),
               alloc_tag, VECS[i].eat);
         tick();
      end
      idle_inputs();

      // R2 / R3: fill every entry
      do_reset();
      for (int i = 0; i < DEPTH; i++) begin
         check(alloc_tag == TW'(i), "R2 fill tag", alloc_tag, i);
         alloc_valid = 1'b1;
         alloc_used  = 3'b111;
         tick();
      end
      #1;
      check(alloc_ready == 1'b0, "R3 full stall", alloc_ready, 0);
      check(alloc_tag == 5'd0, "R2 wrap tag", alloc_tag, 0);
      tick();   // extra request while full
      alloc_valid = 1'b0;
      #1;
      check(alloc_tag == 5'd0, "R3 ignored alloc tag", alloc_tag, 0);
      check(retire_valid == 1'b0, "R3 ignored alloc retire", retire_valid, 0);

      // Finish group 0 through all three lanes at once (R5)
      cmp_valid = 3'b111;
      cmp_tag   = {5'd0, 5'd0, 5'd0};
      cmp_slot  = {2'd2, 2'd1, 2'd0};
      tick();
      cmp_valid = '0;
      #1;
      check(retire_valid == 1'b1, "R4 full group retire", retire_valid, 1);
      check(retire_tag == 5'd0, "R4 retire tag", retire_tag, 0);
      check(alloc_ready == 1'b0, "R3 still full", alloc_ready, 0);
      tick();
      check(alloc_ready == 1'b1, "R3 space after retire", alloc_ready, 1);
      check(retire_valid == 1'b0, "R6 next not ready", retire_valid, 0);
      check(retire_tag == 5'd1, "R6 head advanced", retire_tag, 1);
      alloc_valid = 1'b1;
      tick();
      alloc_valid = 1'b0;
      #1;
      check(alloc_tag == 5'd1, "R2 reuse wrapped entry", alloc_tag, 1);
      check(alloc_ready == 1'b0, "R3 full again", alloc_ready, 0);

      // R9: partial head, complete younger, then flush
      cmp_valid = 3'b111;
      cmp_tag   = {5'd2, 5'd1, 5'd1};
      cmp_slot  = {2'd0, 2'd1, 2'd0};
      tick();
      cmp_valid = 3'b011;
      cmp_tag   = {5'd0, 5'd2, 5'd2};
      cmp_slot  = {2'd0, 2'd2, 2'd1};
      tick();
      cmp_valid = '0;
      #1;
      check(retire_valid == 1'b0, "R6 younger waits", retire_valid, 0);
      flush     = 1'b1;
      cmp_valid = 3'b001;
      cmp_tag   = {5'd0, 5'd0, 5'd1};
      cmp_slot  = {2'd0, 2'd0, 2'd2};
      #1;
      check(retire_valid == 1'b0, "R9 no retire in flush", retire_valid, 0);
      check(alloc_ready == 1'b0, "R9 no alloc in flush", alloc_ready, 0);
      tick();
      idle_inputs();
      #1;
      check(alloc_ready == 1'b1, "R9 ready after flush", alloc_ready, 1);
      check(alloc_tag == 5'd0, "R9 alloc tag reset", alloc_tag, 0);
      check(retire_tag == 5'd0, "R9 retire tag reset", retire_tag, 0);
      check(retire_valid == 1'b0, "R9 retire after flush", retire_valid, 0);
      tick();
      check(retire_valid == 1'b0, "R9 old groups dropped", retire_valid, 0);
      alloc_valid = 1'b1;
      alloc_used  = 3'b000;
      tick();
      idle_inputs();
      #1;
      check(retire_valid == 1'b1, "R7 empty triplet retires", retire_valid, 1);
      check(retire_tag == 5'd0, "R9 numbering restarts", retire_tag, 0);
      tick();

      finish_run();
   end

endmodule